// File: doc/BRIEF.md
# Sixteen-bit timer/counter with dual compare and centre-aligned PWM

This block is a 16-bit timer/counter that firmware drives over a byte-wide register port. A three-bit clock select either stops the counter or steps it once per tick from a free-running prescaler. Two compare registers, A and B, each drive a match flag and an output pin. In normal mode the counter counts up and wraps at the top of its range. It can also clear itself after a compare-A match, which gives a programmable period. In PWM mode the counter climbs to a fixed TOP value and then falls back to zero, which yields symmetric, centre-aligned pulses on both pins.

Every 16-bit register is reached through a low byte and a high byte that share one staging byte. Firmware writes the high byte first and then the low byte, and both halves land together. A read of the count low byte freezes the matching high byte in the staging byte, so a following high-byte read returns a coherent value even while the counter runs. In PWM mode the compare values are double-buffered and move into use only at TOP. This keeps a compare update in the middle of a period from producing a short or a missing pulse.

Top module: `tmr16_timer`

## Requirements
- R1: Register map on `bus_addr`: 0 control, 1 flags, 2/3 count low/high, 4/5 compare A low/high, 6/7 compare B low/high. A write to any high byte (3, 5, 7) only loads the shared staging byte. A write to a low byte loads that 16-bit register with {staging byte, written byte}, both halves in the same clock.
- R2: A read of address 2 returns count bits 7:0 and copies count bits 15:8 into the staging byte. A read of address 3 returns the staging byte. Compare high bytes read back the register directly.
- R3: Control bits 2:0 select the tick: 0 stops, 1 ticks every clock, 2/3/4/5 tick once per 8/64/256/1024 clocks of a free-running prescaler, and 6 and 7 stop.
- R4: In normal mode (control bit 4 clear) each tick adds one to the count. The step from 0xFFFF to 0x0000 sets flag bit 0.
- R5: With control bit 3 set in normal mode, a tick at which the count equals compare A returns the count to 0x0000.
- R6: A tick at which the count equals compare A (B) sets flag bit 1 (bit 2). In normal mode each such match toggles pin A (B).
- R7: With control bit 4 set, the count runs 0 up to TOP and back down to 0, with period 2*TOP ticks. An upward match clears the pin and a downward match sets it, so a compare value C in 1..TOP-1 gives 2*C high cycles per period.
- R8: In PWM mode flag bit 0 is set on each tick that moves the count away from 0x0000.
- R9: In PWM mode a new compare value takes effect only on the tick at TOP. The pulse already in progress completes with the old value.
- R10: Writing a 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: After reset all registers read 0, both pins are low and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for the staging-byte latch) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp_a | output | 1 | Compare-A match flag |
| flag_cmp_b | output | 1 | Compare-B match flag |
| pin_a | output | 1 | Compare-A output pin |
| pin_b | output | 1 | Compare-B output pin |

## Verification
The assertions assume that the bus never raises write and read in the same cycle, and that firmware places compare values strictly between 0 and TOP while PWM mode is on. The PWM range check also assumes the counter is loaded at or below TOP before PWM is enabled. The bench drives one strobe at a time, loads the count with zero before it turns on PWM, and sweeps compare values only over 1..TOP-1. Duty cycles, wrap points and divided tick counts are computed arithmetically from the TOP parameter and the clock-select code, and are compared against pin high-time totals and count differences read over the bus.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 10;
  localparam int NCH    = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_FLAG   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CPA_LO = 3'd4,
    A_CPA_HI = 3'd5,
    A_CPB_LO = 3'd6,
    A_CPB_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       pwm;
    logic       ctc;
    logic [2:0] csel;
  } ctrl_t;

  // log2 of the prescale ratio for each clock-select code; -1 means no tick
  function automatic int div_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] csel,
  output logic       tick
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] mask;
  logic          run;
  int            sh;

  always_comb pre_d = pre_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    sh   = div_shift(csel);
    run  = (sh >= 0);
    mask = run ? ((ONE << sh) - ONE) : '0;
    tick = run && ((pre_q & mask) == mask);
  end

  // R3: with divide-by-8 no two ticks are adjacent unless the code moved to 1
  p_div8_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && csel == 3'd2) |=> (!tick || csel == 3'd1));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int              WW  = 16,
  parameter logic [WW-1:0]   TOP = 'h3FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwm,
  input  logic          ctc,
  input  logic          hit_a,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  output logic [WW-1:0] cnt,
  output logic          up,
  output logic          ovf_evt
);
  localparam logic [WW-1:0] ALL1 = '1;
  localparam logic [WW-1:0] ONE  = WW'(1);

  logic [WW-1:0] cnt_d;
  logic          up_d;

  always_comb begin
    cnt_d   = cnt;
    up_d    = pwm ? up : 1'b1;
    ovf_evt = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (pwm) begin
        if (cnt == '0) begin
          cnt_d   = ONE;
          up_d    = 1'b1;
          ovf_evt = 1'b1;
        end else if (up) begin
          if (cnt >= TOP) begin
            cnt_d = cnt - ONE;
            up_d  = 1'b0;
          end else begin
            cnt_d = cnt + ONE;
          end
        end else begin
          cnt_d = cnt - ONE;
        end
      end else if (ctc && hit_a) begin
        cnt_d = '0;
      end else begin
        cnt_d   = cnt + ONE;
        ovf_evt = (cnt == ALL1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= cnt_d;
      up  <= up_d;
    end
  end

  // R3: no tick and no load means the count holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  // R5: clear-on-compare returns to zero on the tick after the match
  p_ctc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !pwm && ctc && hit_a) |=> (cnt == '0));
  // R7: once inside the PWM range the count stays there
  p_pwm_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load && cnt <= TOP) |=> (cnt <= TOP));
  // R8: leaving zero in PWM mode always moves to one
  p_pwm_from_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && tick && !load && cnt == '0) |=> (cnt == ONE && up));
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp #(
  parameter int            WW  = 16,
  parameter logic [WW-1:0] TOP = 'h3FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwm,
  input  logic          up,
  input  logic [WW-1:0] cnt,
  input  logic [WW-1:0] cmp_reg,
  output logic          hit,
  output logic          pin
);
  logic [WW-1:0] buf_q, buf_d, eff;
  logic          pin_d;
  logic          at_top;

  always_comb begin
    at_top = tick && (cnt >= TOP);
    buf_d  = (!pwm || at_top) ? cmp_reg : buf_q;
    eff    = pwm ? buf_q : cmp_reg;
    hit    = tick && (cnt == eff);
    pin_d  = pin;
    if (hit) pin_d = pwm ? !up : !pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      pin   <= 1'b0;
    end else begin
      buf_q <= buf_d;
      pin   <= pin_d;
    end
  end

  // R9: the active compare value only moves at TOP while in PWM mode
  p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !(tick && cnt >= TOP)) |=> $stable(buf_q));
  // R7: an upward match drives the pin low
  p_pwm_up_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && hit && up) |=> !pin);
endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter logic [WORD_W-1:0] PWM_TOP = 16'h03FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              flag_ovf,
  output logic              flag_cmp_a,
  output logic              flag_cmp_b,
  output logic              pin_a,
  output logic              pin_b
);
  localparam int NFLAG = NCH + 1;

  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  reg_addr_e         addr;
  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] temp_q, temp_d;
  logic [WORD_W-1:0] cmp_q [NCH];
  logic [WORD_W-1:0] cmp_d [NCH];
  logic [NFLAG-1:0]  flag_q, flag_d, flag_set, flag_clr;
  logic [WORD_W-1:0] cnt, load_val;
  logic              load, tick, up, ovf_evt;
  logic [NCH-1:0]    hit, pin;

  assign addr = reg_addr_e'(bus_addr);

  tmr16_prescale #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .csel(ctrl_q.csel), .tick(tick)
  );

  tmr16_core #(.WW(WORD_W), .TOP(PWM_TOP)) u_core (
    .clk(clk), .rst_n(rst_s), .tick(tick), .pwm(ctrl_q.pwm), .ctc(ctrl_q.ctc),
    .hit_a(hit[0]), .load(load), .load_val(load_val),
    .cnt(cnt), .up(up), .ovf_evt(ovf_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr16_cmp #(.WW(WORD_W), .TOP(PWM_TOP)) u_cmp (
      .clk(clk), .rst_n(rst_s), .tick(tick), .pwm(ctrl_q.pwm), .up(up),
      .cnt(cnt), .cmp_reg(cmp_q[i]), .hit(hit[i]), .pin(pin[i])
    );
  end

  always_comb begin
    ctrl_d   = ctrl_q;
    temp_d   = temp_q;
    cmp_d    = cmp_q;
    load     = 1'b0;
    load_val = {temp_q, bus_wdata};
    flag_clr = '0;
    if (bus_wr) begin
      case (addr)
        A_CTRL:   ctrl_d = ctrl_t'(bus_wdata[4:0]);
        A_FLAG:   flag_clr = bus_wdata[NFLAG-1:0];
        A_CNT_LO: load = 1'b1;
        A_CPA_LO: cmp_d[0] = {temp_q, bus_wdata};
        A_CPB_LO: cmp_d[1] = {temp_q, bus_wdata};
        default:  temp_d = bus_wdata;
      endcase
    end else if (bus_rd && addr == A_CNT_LO) begin
      temp_d = cnt[WORD_W-1:BYTE_W];
    end
    flag_set = {hit, ovf_evt};
    flag_d   = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
      temp_q <= '0;
      flag_q <= '0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      temp_q <= temp_d;
      flag_q <= flag_d;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   bus_rdata = {3'b000, ctrl_q};
      A_FLAG:   bus_rdata = BYTE_W'(flag_q);
      A_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
      A_CNT_HI: bus_rdata = temp_q;
      A_CPA_LO: bus_rdata = cmp_q[0][BYTE_W-1:0];
      A_CPA_HI: bus_rdata = cmp_q[0][WORD_W-1:BYTE_W];
      A_CPB_LO: bus_rdata = cmp_q[1][BYTE_W-1:0];
      default:  bus_rdata = cmp_q[1][WORD_W-1:BYTE_W];
    endcase
  end

  assign flag_ovf   = flag_q[0];
  assign flag_cmp_a = flag_q[1];
  assign flag_cmp_b = flag_q[2];
  assign pin_a      = pin[0];
  assign pin_b      = pin[1];

  // R1: a low-byte count write joins the staging byte in one clock
  p_low_write_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && addr == A_CNT_LO) |=> (cnt == $past({temp_q, bus_wdata})));
  // R2: a count low-byte read freezes the high byte of that cycle
  p_read_latch_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_rd && !bus_wr && addr == A_CNT_LO) |=> (temp_q == $past(cnt[WORD_W-1:BYTE_W])));
  // R10: write-one clears the overflow flag when no new event arrives
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && addr == A_FLAG && bus_wdata[0] && !ovf_evt) |=> !flag_ovf);
endmodule

// File: tb/tmr16_timer_bench.sv
`timescale 1ns/1ps
module tmr16_timer_bench;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       f_ovf, f_a, f_b, pin_a, pin_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr16_timer #(.PWM_TOP(16'(T))) u_tmr16_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .flag_ovf(f_ovf), .flag_cmp_a(f_a),
    .flag_cmp_b(f_b), .pin_a(pin_a), .pin_b(pin_b)
  );

  // pin monitors: edge counts, high totals, high-run lengths of pin A
  int edges_a = 0, edges_b = 0, hi_a = 0, hi_b = 0;
  int run_a = 0, last_run_a = 0, runs_a = 0;
  logic pa_prev = 1'b0, pb_prev = 1'b0;
  always @(negedge clk) begin
    if (pin_a != pa_prev) edges_a++;
    if (pin_b != pb_prev) edges_b++;
    pa_prev = pin_a;
    pb_prev = pin_b;
    if (pin_a) hi_a++;
    if (pin_b) hi_b++;
    if (pin_a) run_a++;
    else if (run_a != 0) begin
      last_run_a = run_a;
      runs_a++;
      run_a = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic write16(input logic [2:0] lo, input logic [15:0] v);
    bus_write(lo + 3'd1, v[15:8]);
    bus_write(lo, v[7:0]);
  endtask

  task automatic read_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(3'd2, lo);
    bus_read(3'd3, hi);
    v = {hi, lo};
  endtask

  initial begin
    #(4 * 120000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v1, v2;
    int e0, e1, f0, h0, h1, n0;

    repeat (3) @(negedge clk);
    chk("R11 pin_a in reset", int'(pin_a), 0);
    rst_n = 1'b1;
    idle(4);
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), b);
      chk($sformatf("R11 reg %0d after reset", a), int'(b), 0);
    end
    chk("R11 pins after reset", int'({pin_a, pin_b}), 0);

    // R1: shared staging byte, high written first
    bus_write(3'd7, 8'h12);
    bus_write(3'd2, 8'h34);
    read_cnt(v1);
    chk("R1 count from other high byte", int'(v1), 'h1234);
    bus_read(3'd7, b);
    chk("R1 compare B high untouched", int'(b), 0);
    write16(3'd4, 16'hABCD);
    bus_read(3'd4, b);
    chk("R1 compare A low", int'(b), 'hCD);
    bus_read(3'd5, b);
    chk("R1 compare A high", int'(b), 'hAB);

    // R3: clock-select sweep; count difference over 2048 clocks
    write16(3'd4, 16'h8000);
    write16(3'd6, 16'h8000);
    for (int cs = 0; cs < 8; cs++) begin
      int exp;
      case (cs)
        1: exp = 2048;
        2: exp = 2048 / 8;
        3: exp = 2048 / 64;
        4: exp = 2048 / 256;
        5: exp = 2048 / 1024;
        default: exp = 0;
      endcase
      bus_write(3'd0, 8'(cs));
      read_cnt(v1);
      idle(2046);
      read_cnt(v2);
      chk($sformatf("R3 ticks for code %0d", cs), int'(16'(v2 - v1)), exp);
    end

    // R2: low read at 0x00FF freezes 0x00 even as count passes 0x0100
    bus_write(3'd0, 8'h01);
    write16(3'd2, 16'h00F0);
    idle(15);
    read_cnt(v1);
    chk("R2 coherent count across byte carry", int'(v1), 'h00FF);

    // R4: wrap from 0xFFFF sets overflow
    bus_write(3'd0, 8'h00);
    bus_write(3'd1, 8'h07);
    write16(3'd2, 16'hFFF0);
    bus_write(3'd0, 8'h01);
    idle(30);
    bus_write(3'd0, 8'h00);
    read_cnt(v1);
    chk("R4 count after 31 ticks", int'(v1), 'h000F);
    bus_read(3'd1, b);
    chk("R4 overflow flag", int'(b), 'h01);

    // R5/R6: clear on compare A, period 10
    bus_write(3'd1, 8'h07);
    write16(3'd4, 16'd9);
    write16(3'd6, 16'd5);
    write16(3'd2, 16'd0);
    bus_write(3'd0, 8'h09);
    for (int k = 0; k < 3; k++) begin
      read_cnt(v1);
      idle(35 + 4 * k);
      read_cnt(v2);
      chk("R5 count modulo compare A", int'(v2), (int'(v1) + 37 + 4 * k) % 10);
    end
    bus_write(3'd0, 8'h00);
    bus_read(3'd1, b);
    chk("R6 match flags without overflow", int'(b), 'h06);
    bus_write(3'd1, 8'h00);
    bus_read(3'd1, b);
    chk("R10 writing zero keeps flags", int'(b), 'h06);
    bus_write(3'd1, 8'h02);
    bus_read(3'd1, b);
    chk("R10 clear flag A only", int'(b), 'h04);
    bus_write(3'd1, 8'h04);
    bus_read(3'd1, b);
    chk("R10 clear flag B", int'(b), 'h00);

    // R6: normal-mode toggling, period 4 ticks
    write16(3'd4, 16'd3);
    write16(3'd6, 16'd1);
    write16(3'd2, 16'd0);
    bus_write(3'd0, 8'h09);
    idle(8);
    @(negedge clk); #1 e0 = edges_a; f0 = edges_b;
    repeat (40) @(negedge clk);
    #1;
    chk("R6 pin A toggles", edges_a - e0, 10);
    chk("R6 pin B toggles", edges_b - f0, 10);

    // R7: PWM duty sweep, high time 2*C per period
    bus_write(3'd0, 8'h00);
    write16(3'd2, 16'd0);
    bus_write(3'd0, 8'h11);
    for (int c = 1; c < T; c++) begin
      write16(3'd4, 16'(c));
      write16(3'd6, 16'(T - c));
      idle(4 * T);
      @(negedge clk); #1 h0 = hi_a; h1 = hi_b;
      repeat (2 * T) @(negedge clk);
      #1;
      chk($sformatf("R7 pin A high time C=%0d", c), hi_a - h0, 2 * c);
      chk($sformatf("R7 pin B high time C=%0d", T - c), hi_b - h1, 2 * (T - c));
    end
    for (int k = 0; k < 5; k++) begin
      read_cnt(v1);
      chk("R7 count within TOP", int'(v1 <= 16'(T)), 1);
      idle(3 + k);
    end

    // R8: PWM overflow on leaving zero
    bus_write(3'd1, 8'h07);
    bus_read(3'd1, b);
    chk("R8 flag cleared before wait", int'(b[0]), 0);
    idle(2 * T + 4);
    bus_read(3'd1, b);
    chk("R8 PWM overflow flag", int'(b[0]), 1);

    // R9: compare change mid-period waits for TOP
    write16(3'd4, 16'd12);
    idle(4 * T);
    while (pin_a !== 1'b0) @(negedge clk);
    while (pin_a !== 1'b1) @(negedge clk);
    n0 = runs_a;
    write16(3'd4, 16'd3);
    while (runs_a == n0) @(negedge clk);
    chk("R9 pulse finishes with old compare", last_run_a, 24);
    while (runs_a == n0 + 1) @(negedge clk);
    chk("R9 next pulse uses new compare", last_run_a, 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule